// File: doc/BRIEF.md
# PFC Fault and Mode Supervisor

This block watches three digitized quantities of a boost power-factor stage and decides whether the power switch may be driven. The three quantities are the feedback current, which scales with the output link voltage, the line current, which scales with the rectified input, and the tracked peak of the line. A new set of values arrives with a one-cycle valid strobe. All decisions are taken on those strobes, and the block holds its state between them.

Several checks run in parallel. A hysteretic comparator selects between the startup and normal regulation modes. A second hysteretic comparator removes gate drive on overvoltage. A plausibility check compares the feedback against the line, because a broken feedback sense path makes the link look lower than the input. An overload timer counts startup re-entries after normal regulation has been reached. When the accumulated overload passes its limit, the timer forces a long shutdown and then lets the stage try again. Each fault also leaves a sticky status flag that software clears by issuing a read strobe.

Thresholds are given in feedback-current units. The nominal reference is 129, the overvoltage trip is 136 and its hysteresis is 2. The startup level is 90% of the reference, which is 116. All overload times are counted in valid samples.

Top module: `pfc_fault_supervisor`

## Requirements
- R1: On a valid sample with feedback below the startup level (116), `startup_mode` is 1 from the next cycle.
- R2: On a valid sample with feedback at or above the reference (129), `startup_mode` becomes 0. For feedback from 116 to 128, the mode keeps its previous value.
- R3: On a valid sample with feedback above 136, `gate_en` is 0 from the next cycle.
- R4: After an overvoltage, gate drive is blocked until a sample with feedback below 134. Samples from 134 to 136 keep it blocked.
- R5: On a valid sample with feedback below the line value, `gate_en` is 0 from the next cycle.
- R6: A sense-path fault clears only on a sample where feedback is at least the line value and also strictly above the line peak.
- R7: The overload timer is armed by a sample taken while the block is in normal mode. While armed, each sample taken in startup mode adds one to an accumulator. The sample that finds the accumulator already at OPP_LIMIT starts a shutdown. The shutdown holds `shutdown`=1 and `gate_en`=0 for SHUT_LEN samples, then releases and disarms the timer. The timer sees the mode as it stood before the current sample.
- R8: NORM_CLR consecutive samples taken in normal mode reset the overload accumulator to zero.
- R9: `gate_en` is 1 exactly when no overvoltage, no sense-path fault and no shutdown is active. Overvoltage blocks the gate whatever the other conditions are.
- R10: Each status flag (`stat_ovp`, `stat_sense`, `stat_ovl`) is set by its fault and stays set. On a cycle with `stat_rd`=1, each flag is reloaded with whether its fault is active that cycle. `stat_ovp` and `stat_sense` follow their fault flags with one cycle of lag. `stat_ovl` sets on the same edge that starts a shutdown.
- R11: After reset, `startup_mode`=1, `gate_en`=0 (the sense path is treated as failed until proven good), `shutdown`=0 and all status flags are 0.
- R12: While `smp_vld`=0, the sample inputs have no effect on `startup_mode`, `gate_en` or `shutdown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Strobe marking a new set of samples |
| fb_cur | input | W | Feedback current sample (link voltage) |
| line_cur | input | W | Line current sample (rectified input) |
| line_pk | input | W | Tracked peak of the line sample |
| stat_rd | input | 1 | Status read; reloads the sticky flags |
| startup_mode | output | 1 | 1 in startup mode, 0 in normal mode |
| gate_en | output | 1 | Permission to drive the power switch |
| shutdown | output | 1 | Overload shutdown in progress |
| stat_ovp | output | 1 | Sticky overvoltage flag |
| stat_sense | output | 1 | Sticky sense-path fault flag |
| stat_ovl | output | 1 | Sticky overload shutdown flag |

## Verification
The bench builds the block with OPP_LIMIT=6, SHUT_LEN=10 and NORM_CLR=4 and keeps the default thresholds. The short overload windows make it possible to reach a full trip, the whole shutdown and the restart within a few dozen samples. They also let the bench show the accumulator being cleared by a normal interval, in a sequence that would otherwise trip. The default thresholds put the sweep across both hysteresis bands (116/129 and 134/136) in exact units.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

    localparam int CTR_W = 16;

    typedef logic [CTR_W-1:0] ctr_t;

    typedef struct packed {
        logic armed;
        logic shut;
        ctr_t acc;
        ctr_t clr;
        ctr_t scnt;
    } ovl_st_t;

    typedef struct packed {
        logic ovp;
        logic sense;
        logic ovl;
    } stat_t;

endpackage

// File: rtl/pfc_hyst_flag.sv
module pfc_hyst_flag #(
    parameter int W         = 10,
    parameter int TRIP      = 136,
    parameter int RELEASE   = 134,
    parameter bit HIGH_SIDE = 1'b1,
    parameter bit RST_VAL   = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] x,
    output logic         flag
);
    localparam logic [W-1:0] TRIP_V = W'(TRIP);
    localparam logic [W-1:0] REL_V  = W'(RELEASE);

    logic set_c, rel_c;
    logic flag_d, flag_q;

    generate
        if (HIGH_SIDE) begin : g_high
            assign set_c = (x > TRIP_V);
            assign rel_c = (x < REL_V);
        end else begin : g_low
            assign set_c = (x < TRIP_V);
            assign rel_c = (x >= REL_V);
        end
    endgenerate

    always_comb begin
        flag_d = flag_q;
        if (en) begin
            if (set_c)      flag_d = 1'b1;
            else if (rel_c) flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= RST_VAL;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/pfc_sense_chk.sv
module pfc_sense_chk #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] fb,
    input  logic [W-1:0] line,
    input  logic [W-1:0] pk,
    output logic         fault
);
    logic fault_d, fault_q;

    always_comb begin
        fault_d = fault_q;
        if (en) begin
            if (fb < line)     fault_d = 1'b1;
            else if (fb > pk)  fault_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b1;
        else        fault_q <= fault_d;
    end

    assign fault = fault_q;
endmodule

// File: rtl/pfc_ovl_timer.sv
module pfc_ovl_timer
    import pfc_sup_pkg::*;
#(
    parameter int OPP_LIMIT = 112,
    parameter int SHUT_LEN  = 2500,
    parameter int NORM_CLR  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic startup,
    output logic shut,
    output logic trip
);
    localparam ctr_t LIM_V     = ctr_t'(OPP_LIMIT);
    localparam ctr_t SHUT_LAST = ctr_t'(SHUT_LEN - 1);
    localparam ctr_t CLR_LAST  = ctr_t'(NORM_CLR - 1);

    ovl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        trip = 1'b0;
        if (en) begin
            if (st_q.shut) begin
                if (st_q.scnt == SHUT_LAST) begin
                    st_d.shut  = 1'b0;
                    st_d.scnt  = '0;
                    st_d.armed = 1'b0;
                    st_d.acc   = '0;
                    st_d.clr   = '0;
                end else begin
                    st_d.scnt = st_q.scnt + ctr_t'(1);
                end
            end else if (!startup) begin
                st_d.armed = 1'b1;
                if (st_q.clr == CLR_LAST) begin
                    st_d.acc = '0;
                    st_d.clr = '0;
                end else begin
                    st_d.clr = st_q.clr + ctr_t'(1);
                end
            end else begin
                st_d.clr = '0;
                if (st_q.armed) begin
                    if (st_q.acc == LIM_V) begin
                        trip       = 1'b1;
                        st_d.shut  = 1'b1;
                        st_d.scnt  = '0;
                        st_d.acc   = '0;
                        st_d.armed = 1'b0;
                    end else begin
                        st_d.acc = st_q.acc + ctr_t'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shut = st_q.shut;
endmodule

// File: rtl/pfc_fault_supervisor.sv
module pfc_fault_supervisor
    import pfc_sup_pkg::*;
#(
    parameter int W           = 10,
    parameter int REF         = 129,
    parameter int STARTUP_PCT = 90,
    parameter int OVP_TRIP    = 136,
    parameter int OVP_HYS     = 2,
    parameter int OPP_LIMIT   = 112,
    parameter int SHUT_LEN    = 2500,
    parameter int NORM_CLR    = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] fb_cur,
    input  logic [W-1:0] line_cur,
    input  logic [W-1:0] line_pk,
    input  logic         stat_rd,
    output logic         startup_mode,
    output logic         gate_en,
    output logic         shutdown,
    output logic         stat_ovp,
    output logic         stat_sense,
    output logic         stat_ovl
);
    localparam int STARTUP_LVL = (REF * STARTUP_PCT) / 100;
    localparam int OVP_REL     = OVP_TRIP - OVP_HYS;

    logic ovp_f, sense_f, shut_f, trip_p, mode_f;
    stat_t st_d, st_q, ev;

    pfc_hyst_flag #(.W(W), .TRIP(STARTUP_LVL), .RELEASE(REF),
                    .HIGH_SIDE(1'b0), .RST_VAL(1'b1)) u_mode (
        .clk(clk), .rst_n(rst_n), .en(smp_vld), .x(fb_cur), .flag(mode_f));

    pfc_hyst_flag #(.W(W), .TRIP(OVP_TRIP), .RELEASE(OVP_REL),
                    .HIGH_SIDE(1'b1), .RST_VAL(1'b0)) u_ovp (
        .clk(clk), .rst_n(rst_n), .en(smp_vld), .x(fb_cur), .flag(ovp_f));

    pfc_sense_chk #(.W(W)) u_sense (
        .clk(clk), .rst_n(rst_n), .en(smp_vld), .fb(fb_cur),
        .line(line_cur), .pk(line_pk), .fault(sense_f));

    pfc_ovl_timer #(.OPP_LIMIT(OPP_LIMIT), .SHUT_LEN(SHUT_LEN),
                    .NORM_CLR(NORM_CLR)) u_ovl (
        .clk(clk), .rst_n(rst_n), .en(smp_vld), .startup(mode_f),
        .shut(shut_f), .trip(trip_p));

    always_comb begin
        ev.ovp   = ovp_f;
        ev.sense = sense_f;
        ev.ovl   = trip_p;
        if (stat_rd) st_d = ev;
        else         st_d = st_q | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign startup_mode = mode_f;
    assign shutdown     = shut_f;
    assign gate_en      = ovp_f ? 1'b0 : !(sense_f || shut_f);
    assign stat_ovp     = st_q.ovp;
    assign stat_sense   = st_q.sense;
    assign stat_ovl     = st_q.ovl;
endmodule

// File: rtl/pfc_sup_checker.sv
module pfc_sup_checker #(
    parameter int W           = 10,
    parameter int REF         = 129,
    parameter int STARTUP_PCT = 90,
    parameter int OVP_TRIP    = 136
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smp_vld,
    input logic [W-1:0] fb_cur,
    input logic [W-1:0] line_cur,
    input logic         startup_mode,
    input logic         gate_en,
    input logic         shutdown,
    input logic         stat_ovp
);
    localparam logic [W-1:0] LO_V   = W'((REF * STARTUP_PCT) / 100);
    localparam logic [W-1:0] REF_V  = W'(REF);
    localparam logic [W-1:0] TRIP_V = W'(OVP_TRIP);

    AST_STARTUP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && fb_cur < LO_V |=> startup_mode); // R1
    AST_NORMAL_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && fb_cur >= REF_V |=> !startup_mode); // R2
    AST_OVP_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && fb_cur > TRIP_V |=> !gate_en); // R3
    AST_SENSE_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && fb_cur < line_cur |=> !gate_en); // R5
    AST_SHUT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !gate_en); // R9
    AST_OVP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && fb_cur > TRIP_V |=> ##1 stat_ovp); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(startup_mode) && $stable(gate_en) && $stable(shutdown)); // R12
endmodule

bind pfc_fault_supervisor pfc_sup_checker #(
    .W(W), .REF(REF), .STARTUP_PCT(STARTUP_PCT), .OVP_TRIP(OVP_TRIP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .fb_cur(fb_cur),
    .line_cur(line_cur), .startup_mode(startup_mode), .gate_en(gate_en),
    .shutdown(shutdown), .stat_ovp(stat_ovp)
);

// File: tb/sim_pfc_fault_supervisor.sv
`timescale 1ns/1ps
module sim_pfc_fault_supervisor;
    localparam int W = 10, OPP_LIMIT = 6, SHUT_LEN = 10, NORM_CLR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0, stat_rd = 1'b0;
    logic [W-1:0] fb_cur = '0, line_cur = '0, line_pk = '0;
    logic startup_mode, gate_en, shutdown, stat_ovp, stat_sense, stat_ovl;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pfc_fault_supervisor #(.W(W), .OPP_LIMIT(OPP_LIMIT), .SHUT_LEN(SHUT_LEN),
                           .NORM_CLR(NORM_CLR)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .fb_cur(fb_cur),
        .line_cur(line_cur), .line_pk(line_pk), .stat_rd(stat_rd),
        .startup_mode(startup_mode), .gate_en(gate_en), .shutdown(shutdown),
        .stat_ovp(stat_ovp), .stat_sense(stat_sense), .stat_ovl(stat_ovl));

    // behavioural reference
    bit m_start, m_ovp, m_sense, m_shut, m_armed;
    int m_acc, m_clr, m_scnt;
    bit s_ovp, s_sense, s_ovl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 1; m_ovp = 0; m_sense = 1; m_shut = 0; m_armed = 0;
            m_acc = 0; m_clr = 0; m_scnt = 0; s_ovp = 0; s_sense = 0; s_ovl = 0;
        end else begin
            bit e_ovp, e_sense, e_ovl;
            e_ovp = m_ovp; e_sense = m_sense; e_ovl = 0;
            if (smp_vld) begin
                if (m_shut) begin
                    if (m_scnt == SHUT_LEN - 1) begin
                        m_shut = 0; m_scnt = 0; m_armed = 0; m_acc = 0; m_clr = 0;
                    end else m_scnt++;
                end else if (!m_start) begin
                    m_armed = 1;
                    if (m_clr == NORM_CLR - 1) begin m_acc = 0; m_clr = 0; end
                    else m_clr++;
                end else begin
                    m_clr = 0;
                    if (m_armed) begin
                        if (m_acc == OPP_LIMIT) begin
                            e_ovl = 1; m_shut = 1; m_scnt = 0; m_acc = 0; m_armed = 0;
                        end else m_acc++;
                    end
                end
                if (int'(fb_cur) < 116) m_start = 1;
                else if (int'(fb_cur) >= 129) m_start = 0;
                if (int'(fb_cur) > 136) m_ovp = 1;
                else if (int'(fb_cur) < 134) m_ovp = 0;
                if (fb_cur < line_cur) m_sense = 1;
                else if (fb_cur > line_pk) m_sense = 0;
            end
            if (stat_rd) begin s_ovp = e_ovp; s_sense = e_sense; s_ovl = e_ovl; end
            else begin s_ovp |= e_ovp; s_sense |= e_sense; s_ovl |= e_ovl; end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1/R2 startup_mode", startup_mode, m_start);
            chk("R9 gate_en", gate_en, !(m_ovp || m_sense || m_shut));
            chk("R7 shutdown", shutdown, m_shut);
            chk("R10 stat_ovp", stat_ovp, s_ovp);
            chk("R10 stat_sense", stat_sense, s_sense);
            chk("R10 stat_ovl", stat_ovl, s_ovl);
        end
    end

    task automatic step(input int f, input int l, input int p, input bit v, input bit r);
        @(negedge clk);
        fb_cur = W'(f); line_cur = W'(l); line_pk = W'(p); smp_vld = v; stat_rd = r;
        @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step(0, 0, 0, 0, 0);
        // R11 reset state
        chk("R11 startup", startup_mode, 1'b1);
        chk("R11 gate", gate_en, 1'b0);
        chk("R11 shutdown", shutdown, 1'b0);
        chk("R11 stat_ovp", stat_ovp, 1'b0);
        chk("R11 stat_ovl", stat_ovl, 1'b0);

        step(120, 50, 100, 1, 0);
        chk("R2 hold startup in band", startup_mode, 1'b1);
        chk("R6 sense cleared", gate_en, 1'b1);
        step(130, 50, 100, 1, 1);
        chk("R2 normal at reference", startup_mode, 1'b0);
        step(125, 50, 100, 1, 1);
        chk("R2 hold normal in band", startup_mode, 1'b0);

        step(137, 50, 100, 1, 0);
        chk("R3 ovp cutoff", gate_en, 1'b0);
        step(135, 50, 100, 1, 0);
        chk("R4 ovp hold 135", gate_en, 1'b0);
        step(134, 50, 100, 1, 0);
        chk("R4 ovp hold 134", gate_en, 1'b0);
        chk("R10 stat_ovp set", stat_ovp, 1'b1);
        step(133, 50, 100, 1, 0);
        chk("R4 ovp release", gate_en, 1'b1);

        step(200, 500, 600, 0, 0);
        chk("R12 ignored gate", gate_en, 1'b1);
        chk("R12 ignored mode", startup_mode, 1'b0);
        step(130, 50, 100, 1, 1);
        step(130, 50, 100, 0, 0);
        chk("R10 cleared on read", stat_ovp, 1'b0);

        step(120, 125, 128, 1, 0);
        chk("R5 sense cutoff", gate_en, 1'b0);
        step(126, 125, 128, 1, 0);
        chk("R6 held below peak", gate_en, 1'b0);
        step(130, 125, 128, 1, 0);
        chk("R6 released", gate_en, 1'b1);

        // overload with a clearing normal interval between bursts
        repeat (3) step(100, 50, 90, 1, 0);
        repeat (5) step(130, 50, 90, 1, 0);
        repeat (6) step(100, 50, 90, 1, 0);
        chk("R8 accumulator cleared", shutdown, 1'b0);
        repeat (3) step(100, 50, 90, 1, 0);
        chk("R7 shutdown entered", shutdown, 1'b1);
        chk("R7 gate blocked", gate_en, 1'b0);
        step(130, 50, 90, 1, 0);
        chk("R10 stat_ovl", stat_ovl, 1'b1);
        repeat (SHUT_LEN) step(130, 50, 90, 1, 0);
        chk("R7 restart", shutdown, 1'b0);
        repeat (4) step(130, 50, 90, 1, 1);
        chk("R9 gate back", gate_en, 1'b1);
        // repeated overload with no intervening clear reaches a second trip
        repeat (OPP_LIMIT + 3) step(100, 50, 90, 1, 0);
        chk("R7 second trip", shutdown, 1'b1);
        repeat (SHUT_LEN + 4) step(100, 50, 90, 1, 0);
        chk("R7 disarmed after restart", shutdown, 1'b0);

        step(100, 50, 90, 0, 0);
        done = 1;
        summary();
        $finish;
    end
endmodule